// File: doc/BRIEF.md
# Interrupt Pending Aggregator

The block gathers interrupt requests from a set of on-chip devices into one sticky device-interrupt register. Each device owns one bit. A request sets its bit, and the bit stays set until software clears it with a write-one-to-clear strobe. A software-owned mask register selects which device bits may interrupt the processor. Any unmasked pending device bit raises the processor's device pending line, which is bit 2 of the 8-bit interrupt-pending (IP) field. The other seven IP bits come from outside the block, for example the timer and the software interrupts.

From the processor status word and the assembled IP field, the block derives a single take-interrupt request. The status word fields are:

- Interrupt enable: bit 0.
- Exception level: bit 1.
- Error level: bit 2.
- Per-line interrupt mask: bits 15:8.

The request is issued only when three conditions all hold:

- Interrupts are enabled.
- The processor is in neither exception level nor error level.
- At least one pending IP line is also enabled by the status mask.

The request is combinational from the status input and registered state. It therefore drops in the same cycle the processor enters exception level. The exception entry itself and register-bus decoding are handled by the surrounding logic.

Top module: `irq_pend_agg`

## Requirements
- R1: After synchronous reset, `dev_irq` and `irq_mask` are all zero and `cause_ip[2]` is 0.
- R2: `src_req[i]` high at a rising edge sets `dev_irq[i]` from the next cycle; the bit stays set after `src_req[i]` returns low until cleared.
- R3: With `clr_we` high, each bit set in `clr_data` clears the matching `dev_irq` bit at the edge; bits with `clr_data` 0 are unchanged, and a request in the same cycle wins over the clear (bit stays 1).
- R4: With `mask_we` high, bits set in `mask_set` set `irq_mask` bits and bits set in `mask_clr` clear them; set wins when both name the same bit; with `mask_we` low the mask holds.
- R5: `cause_ip[2]` is 1 exactly when `dev_irq & irq_mask` is nonzero.
- R6: `cause_ip[7:3]` and `cause_ip[1:0]` equal the same bits of `ext_ip`; `ext_ip[2]` has no effect on any output.
- R7: `take_irq` is 0 whenever `status_in[0]` (interrupt enable) is 0.
- R8: `take_irq` is 0 whenever `status_in[1]` (exception level) or `status_in[2]` (error level) is 1, including the very cycle that bit becomes 1.
- R9: When `status_in[0]`=1 and `status_in[2:1]`=0, `take_irq` equals the OR-reduction of `status_in[15:8] & cause_ip`, combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Per-device interrupt request, bit i = device i |
| clr_we | input | 1 | Write-one-to-clear strobe for the device register |
| clr_data | input | N_SRC | Bits of the device register to clear |
| mask_we | input | 1 | Mask write strobe |
| mask_set | input | N_SRC | Mask bits to set |
| mask_clr | input | N_SRC | Mask bits to clear |
| ext_ip | input | 8 | External IP lines; bit 2 unused |
| status_in | input | 32 | Processor status word |
| dev_irq | output | N_SRC | Sticky device interrupt register |
| irq_mask | output | N_SRC | Device interrupt mask register |
| cause_ip | output | 8 | Assembled interrupt-pending field |
| take_irq | output | 1 | Take-interrupt request |

## Verification
On every cycle, the assertions check the register update rules:

- a request sets its bit;
- a clear without a request drops it;
- an untouched bit holds;
- the device pending line stays low with an empty mask;
- `take_irq` never rises unless enable is set, both level bits are clear and an enabled IP line is pending.

Only the bench scenarios can show the remaining behaviours:

- the set-over-clear priorities on both registers;
- the independence of `ext_ip[2]`;
- that the request really is issued for every enabling combination.

The bench covers the last point by sweeping all enable, level and mask combinations against a model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IP_W      = 8;
    localparam int STAT_W    = 32;
    localparam int IE_POS    = 0;
    localparam int EXL_POS   = 1;
    localparam int ERL_POS   = 2;
    localparam int IM_LSB    = 8;
    localparam int DEV_IP    = 2;

    typedef struct packed {
        logic erl;
        logic exl;
        logic ie;
    } mode_t;

    typedef logic [IP_W-1:0] ip_t;

    function automatic mode_t decode_mode(input logic [STAT_W-1:0] st);
        mode_t m;
        m.ie  = st[IE_POS];
        m.exl = st[EXL_POS];
        m.erl = st[ERL_POS];
        return m;
    endfunction

    function automatic logic mode_open(input mode_t m);
        return m.ie && !m.exl && !m.erl;
    endfunction

    function automatic ip_t im_field(input logic [STAT_W-1:0] st);
        return st[IM_LSB +: IP_W];
    endfunction
endpackage

// File: rtl/irq_sticky_bits.sv
module irq_sticky_bits #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q[i] <= 1'b0;
            else if (set_v[i]) q[i] <= 1'b1;
            else if (clr_v[i]) q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_v[i] |=> q[i]);                                   // R2, R4
        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (clr_v[i] && !set_v[i]) |=> !q[i]);                   // R3, R4
        AST_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!set_v[i] && !clr_v[i]) |=> $stable(q[i]));          // R2, R4
    end
endmodule

// File: rtl/irq_take_gate.sv
module irq_take_gate
    import irq_pkg::*;
(
    input  logic [STAT_W-1:0] status,
    input  ip_t               ip,
    output logic              take
);
    mode_t mode;
    ip_t   hits;

    always_comb begin
        mode = decode_mode(status);
        hits = im_field(status) & ip;
        take = mode_open(mode) && (|hits);
    end
endmodule

// File: rtl/irq_pend_agg.sv
module irq_pend_agg
    import irq_pkg::*;
#(
    parameter int N_SRC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              clr_we,
    input  logic [N_SRC-1:0]  clr_data,
    input  logic              mask_we,
    input  logic [N_SRC-1:0]  mask_set,
    input  logic [N_SRC-1:0]  mask_clr,
    input  logic [IP_W-1:0]   ext_ip,
    input  logic [STAT_W-1:0] status_in,
    output logic [N_SRC-1:0]  dev_irq,
    output logic [N_SRC-1:0]  irq_mask,
    output logic [IP_W-1:0]   cause_ip,
    output logic              take_irq
);
    logic [N_SRC-1:0] dev_clr, msk_set, msk_clr;
    logic             dev_pend;

    always_comb begin
        dev_clr = clr_we  ? clr_data : '0;
        msk_set = mask_we ? mask_set : '0;
        msk_clr = mask_we ? mask_clr : '0;
    end

    irq_sticky_bits #(.W(N_SRC)) u_dev (
        .clk(clk), .rst(rst), .set_v(src_req), .clr_v(dev_clr), .q(dev_irq)
    );

    irq_sticky_bits #(.W(N_SRC)) u_mask (
        .clk(clk), .rst(rst), .set_v(msk_set), .clr_v(msk_clr), .q(irq_mask)
    );

    always_comb begin
        dev_pend = |(dev_irq & irq_mask);
        cause_ip = ext_ip;
        cause_ip[DEV_IP] = dev_pend;
    end

    irq_take_gate u_gate (
        .status(status_in), .ip(cause_ip), .take(take_irq)
    );

    AST_NOMASK_NOPEND: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> !cause_ip[DEV_IP]);                       // R5
    AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> status_in[IE_POS]);                               // R7
    AST_TAKE_BLOCKED_LVL: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> !(status_in[EXL_POS] || status_in[ERL_POS]));     // R8
    AST_TAKE_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> (|(status_in[IM_LSB +: IP_W] & cause_ip)));       // R9
endmodule

// File: tb/sim_irq_pend_agg.sv
module sim_irq_pend_agg;
    localparam int N = 6;

    logic           clk = 0;
    logic           rst;
    logic [N-1:0]   src_req, clr_data, mask_set, mask_clr;
    logic           clr_we, mask_we;
    logic [7:0]     ext_ip;
    logic [31:0]    status_in;
    logic [N-1:0]   dev_irq, irq_mask;
    logic [7:0]     cause_ip;
    logic           take_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [N-1:0] dev_m, mask_m;

    always #2.5 clk = ~clk;

    irq_pend_agg #(.N_SRC(N)) u0 (
        .clk(clk), .rst(rst), .src_req(src_req), .clr_we(clr_we),
        .clr_data(clr_data), .mask_we(mask_we), .mask_set(mask_set),
        .mask_clr(mask_clr), .ext_ip(ext_ip), .status_in(status_in),
        .dev_irq(dev_irq), .irq_mask(irq_mask), .cause_ip(cause_ip),
        .take_irq(take_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_ip();
        logic [7:0] e = ext_ip;
        e[2] = |(dev_m & mask_m);
        return e;
    endfunction

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            dev_m = '0; mask_m = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (src_req[i]) dev_m[i] = 1'b1;
                else if (clr_we && clr_data[i]) dev_m[i] = 1'b0;
                if (mask_we && mask_set[i]) mask_m[i] = 1'b1;
                else if (mask_we && mask_clr[i]) mask_m[i] = 1'b0;
            end
        end
        @(negedge clk);
        src_req = '0; clr_we = 0; clr_data = '0;
        mask_we = 0; mask_set = '0; mask_clr = '0;
    endtask

    task automatic t_reset();
        src_req = '1; mask_we = 1; mask_set = '1;
        rst = 1; tick(); tick(); rst = 0;
        check("R1 dev", dev_irq, 0);
        check("R1 mask", irq_mask, 0);
        check("R1 ip2", cause_ip[2], 0);
    endtask

    task automatic t_sticky();
        src_req = 6'b000101; tick();
        check("R2 set", dev_irq, dev_m);
        tick(); tick();
        check("R2 hold", dev_irq, 6'b000101);
    endtask

    task automatic t_w1c();
        clr_we = 1; clr_data = 6'b000001; tick();
        check("R3 clear one", dev_irq, 6'b000100);
        src_req = 6'b100000; clr_we = 1; clr_data = 6'b100100; tick();
        check("R3 req wins", dev_irq, 6'b100000);
        clr_we = 1; clr_data = 6'b000000; tick();
        check("R3 zero no effect", dev_irq, dev_m);
    endtask

    task automatic t_mask();
        mask_we = 1; mask_set = 6'b001100; tick();
        check("R4 set", irq_mask, 6'b001100);
        mask_we = 1; mask_set = 6'b010000; mask_clr = 6'b011000; tick();
        check("R4 set wins/clear", irq_mask, 6'b010100);
        mask_we = 0; mask_set = '1; tick();
        check("R4 no we", irq_mask, 6'b010100);
    endtask

    task automatic t_ip2();
        ext_ip = 8'h00; clr_we = 1; clr_data = '1; tick();
        src_req = 6'b000010; tick();
        check("R5 unmasked off", cause_ip[2], 0);
        src_req = 6'b010000; tick();
        check("R5 masked on", cause_ip[2], 1);
        mask_we = 1; mask_clr = 6'b010000; tick();
        check("R5 mask drop", cause_ip[2], exp_ip()[2]);
    endtask

    task automatic t_ext();
        ext_ip = 8'hFF; #1;
        check("R6 ext ff", cause_ip, exp_ip());
        ext_ip = 8'h04; #1;
        check("R6 ext bit2 ignored", cause_ip, exp_ip());
        status_in = 32'h0000_0401; #1;
        check("R6 ext bit2 no take", take_irq, 0);
        ext_ip = 8'h80; #1;
        check("R6 ext bit7", cause_ip, exp_ip());
    endtask

    task automatic t_sweep(input logic [7:0] e);
        ext_ip = e; #1;
        for (int m = 0; m < 8; m++) begin
            for (int im = 0; im < 256; im++) begin
                logic exp;
                status_in = {16'h0, im[7:0], 5'b0, m[2:0]};
                #1;
                exp = m[0] && !m[1] && !m[2] && (|(im[7:0] & exp_ip()));
                if (!m[0]) check("R7 ie off", take_irq, 0);
                else if (m[1] || m[2]) check("R8 level blocks", take_irq, 0);
                else check("R9 take", take_irq, exp);
            end
        end
    endtask

    task automatic t_exl_edge();
        ext_ip = 8'h80; status_in = 32'h0000_8001; #1;
        check("R9 take on", take_irq, 1);
        status_in = 32'h0000_8003; #1;
        check("R8 exl same cycle", take_irq, 0);
        status_in = 32'h0000_8005; #1;
        check("R8 erl same cycle", take_irq, 0);
    endtask

    initial begin
        #(5ns * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        src_req = '0; clr_we = 0; clr_data = '0; mask_we = 0;
        mask_set = '0; mask_clr = '0; ext_ip = '0; status_in = '0; rst = 1;
        dev_m = '0; mask_m = '0;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_w1c();
        t_mask();
        t_ip2();
        t_ext();
        t_sweep(8'h00);
        src_req = 6'b010000; mask_we = 1; mask_set = 6'b010000; tick();
        t_sweep(8'h01);
        t_sweep(8'h80);
        t_exl_edge();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule